// File: doc/BRIEF.md
# SPI Status Flags with Sequenced Clearing

This block holds the three status flags of a serial peripheral: receive complete, transmit empty and mode fault. The shift engine reports events by single-cycle pulses and by a few mode levels. A simple synchronous register bus reads the status byte and performs the accesses that clear the flags. The bus has an address, read and write strobes, and a high and a low byte lane.

No flag can be cleared by one access alone. A status read that sees a flag set arms that flag's clear. A later matching access then clears it. For receive complete, that access is a data-register read, and which reads count depends on the transfer width. For transmit empty, it is the engine's report that the transmit buffer was written. For mode fault, it is a write to control register 1. A new set event always overrides a pending clear. Each flag, gated by its own enable input, drives an interrupt request.

Top module: `spi_flag_status`

## Requirements
- R1: After reset the status byte reads 0x20: transmit empty is 1, receive complete and mode fault are 0, and no clear is armed.
- R2: The status byte is read at address 0x3 in the same cycle as the read strobe. Receive complete is bit 7, transmit empty is bit 5 and mode fault is bit 4. Bits 6 and 3..0 always read 0, and the read data is 0 when no status read is in progress.
- R3: A write strobe at address 0x3 changes no flag.
- R4: A receive-loaded pulse sets receive complete at the next clock edge.
- R5: In 8-bit width (wide=0), receive complete is cleared by a status read that sees it set, followed by a read of address 0x4 on the low lane only.
- R6: A clearing access that is not preceded by a status read seeing the flag set leaves the flag unchanged.
- R7: In 8-bit width, a read of address 0x4 with both lanes does not clear receive complete.
- R8: A read of address 0x4 on the high lane only never clears receive complete. Such reads can be repeated without effect.
- R9: In 16-bit width (wide=1), after an armed status read, each of the following clears receive complete: a low-lane-only read, a high-lane read followed by a low-lane read, or a read with both lanes.
- R10: A set event that arrives after the arming read, or in the same cycle as the clearing access, keeps the flag set and cancels the arm.
- R11: A transmit-taken pulse sets transmit empty. A transmit-written pulse clears it only after an armed status read.
- R12: Mode fault is set when slave select falls from 1 to 0 while master mode and fault detection are both enabled. It is not set otherwise.
- R13: Mode fault is cleared by an armed status read followed by a write strobe at address 0x0 (control register 1). Without the arm, that write changes nothing.
- R14: Each interrupt output equals its flag ANDed with its enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_lane_hi | input | 1 | High byte lane select |
| bus_lane_lo | input | 1 | Low byte lane select |
| bus_rdata | output | 8 | Status read data |
| ev_rx_load | input | 1 | Received data moved into the data register |
| ev_tx_taken | input | 1 | Engine took the buffered transmit data |
| ev_tx_written | input | 1 | Transmit buffer was written |
| ss_in | input | 1 | Slave-select input level |
| master_en | input | 1 | Master mode |
| fault_det_en | input | 1 | Mode-fault detection enable |
| wide | input | 1 | Transfer width: 0 for 8 bits, 1 for 16 bits |
| rx_irq_en | input | 1 | Receive-complete interrupt enable |
| tx_irq_en | input | 1 | Transmit-empty interrupt enable |
| fault_irq_en | input | 1 | Mode-fault interrupt enable |
| irq_rx | output | 1 | Receive-complete interrupt request |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_fault | output | 1 | Mode-fault interrupt request |

## Verification
The status byte is valid in the same cycle as the read strobe and shows the flags as registered before that edge. Any event, arming read or clearing access takes effect at the next edge. The interrupt outputs follow the registered flags with no extra delay. The bench holds each bus strobe or pulse from one falling edge to just after the next rising edge. The scoreboard monitor samples the read data and the interrupt outputs 1.5 ns after the falling edge of each status read. At that point it sees every effect of earlier operations and none of the current one. Every stimulus is therefore followed by a separate status read, which makes the flag change visible one cycle later.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    // state of one flag with its arming bit
    typedef struct packed {
        logic flag;
        logic arm;
    } flag_st_t;

    // bit positions inside the status byte
    localparam int STAT_W  = 8;
    localparam int RX_POS  = 7;
    localparam int TX_POS  = 5;
    localparam int MF_POS  = 4;

    // slave-select edge detector state
    typedef struct packed {
        logic ss_prev;
    } ss_st_t;
endpackage

// File: rtl/spi_stat_flag.sv
module spi_stat_flag
    import spi_stat_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic stat_rd,
    input  logic clr_acc,
    output logic flag,
    output logic arm
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a status read captures whether the flag was seen set
        if (stat_rd) begin
            st_d.arm = st_q.flag;
        end
        // the second step completes only with a prior arm
        if (clr_acc && st_q.arm) begin
            st_d.flag = 1'b0;
            st_d.arm  = 1'b0;
        end
        // a fresh event wins and withdraws any pending clear
        if (set_ev) begin
            st_d.flag = 1'b1;
            st_d.arm  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= RST_VAL;
            st_q.arm  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign arm  = st_q.arm;
endmodule

// File: rtl/spi_stat_decode.sv
module spi_stat_decode #(
    parameter int          ADDR_W     = 3,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 3'h3,
    parameter logic [ADDR_W-1:0] CTRL1_ADDR = 3'h0,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 3'h4
) (
    input  logic              [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_lane_hi,
    input  logic              bus_lane_lo,
    input  logic              wide,
    output logic              stat_rd,
    output logic              ctrl1_wr,
    output logic              rx_clr_acc
);
    logic data_rd;

    always_comb begin
        stat_rd  = bus_rd && (bus_addr == STAT_ADDR);
        ctrl1_wr = bus_wr && (bus_addr == CTRL1_ADDR);
        data_rd  = bus_rd && (bus_addr == DATA_ADDR);
        // the low lane finishes the receive clear; in 8-bit width a
        // word read does not qualify, in 16-bit width it does
        rx_clr_acc = data_rd && bus_lane_lo && (wide || !bus_lane_hi);
    end
endmodule

// File: rtl/spi_stat_ssfall.sv
module spi_stat_ssfall
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ss_in,
    input  logic master_en,
    input  logic fault_det_en,
    output logic fault_ev
);
    ss_st_t st_d, st_q;

    always_comb begin
        st_d.ss_prev = ss_in;
        fault_ev     = st_q.ss_prev && !ss_in && master_en && fault_det_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ss_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_flag_status.sv
module spi_flag_status
    import spi_stat_pkg::*;
#(
    parameter int          ADDR_W     = 3,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 3'h3,
    parameter logic [ADDR_W-1:0] CTRL1_ADDR = 3'h0,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 3'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_lane_hi,
    input  logic              bus_lane_lo,
    output logic [STAT_W-1:0] bus_rdata,
    input  logic              ev_rx_load,
    input  logic              ev_tx_taken,
    input  logic              ev_tx_written,
    input  logic              ss_in,
    input  logic              master_en,
    input  logic              fault_det_en,
    input  logic              wide,
    input  logic              rx_irq_en,
    input  logic              tx_irq_en,
    input  logic              fault_irq_en,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_fault
);
    logic stat_rd, ctrl1_wr, rx_clr_acc, fault_ev;
    logic rx_flag, rx_arm, tx_flag, tx_arm, mf_flag, mf_arm;

    spi_stat_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
        .CTRL1_ADDR(CTRL1_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_dec (
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_lane_hi(bus_lane_hi), .bus_lane_lo(bus_lane_lo), .wide(wide),
        .stat_rd(stat_rd), .ctrl1_wr(ctrl1_wr), .rx_clr_acc(rx_clr_acc)
    );

    spi_stat_ssfall u_ss (
        .clk(clk), .rst_n(rst_n), .ss_in(ss_in), .master_en(master_en),
        .fault_det_en(fault_det_en), .fault_ev(fault_ev)
    );

    spi_stat_flag #(.RST_VAL(1'b0)) u_rx (
        .clk(clk), .rst_n(rst_n), .set_ev(ev_rx_load), .stat_rd(stat_rd),
        .clr_acc(rx_clr_acc), .flag(rx_flag), .arm(rx_arm)
    );

    spi_stat_flag #(.RST_VAL(1'b1)) u_tx (
        .clk(clk), .rst_n(rst_n), .set_ev(ev_tx_taken), .stat_rd(stat_rd),
        .clr_acc(ev_tx_written), .flag(tx_flag), .arm(tx_arm)
    );

    spi_stat_flag #(.RST_VAL(1'b0)) u_mf (
        .clk(clk), .rst_n(rst_n), .set_ev(fault_ev), .stat_rd(stat_rd),
        .clr_acc(ctrl1_wr), .flag(mf_flag), .arm(mf_arm)
    );

    always_comb begin
        bus_rdata = '0;
        if (stat_rd) begin
            bus_rdata[RX_POS] = rx_flag;
            bus_rdata[TX_POS] = tx_flag;
            bus_rdata[MF_POS] = mf_flag;
        end
        irq_rx    = rx_flag && rx_irq_en;
        irq_tx    = tx_flag && tx_irq_en;
        irq_fault = mf_flag && fault_irq_en;
    end
endmodule

// File: rtl/spi_flag_status_chk.sv
module spi_flag_status_chk #(
    parameter int          ADDR_W     = 3,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 3'h3,
    parameter logic [ADDR_W-1:0] CTRL1_ADDR = 3'h0,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 3'h4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_lane_hi,
    input logic              bus_lane_lo,
    input logic [7:0]        bus_rdata,
    input logic              ev_rx_load,
    input logic              ev_tx_taken,
    input logic              rx_flag,
    input logic              mf_flag,
    input logic              mf_arm,
    input logic              tx_flag,
    input logic              irq_rx
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & 8'h4F) == 8'h00);

    // R4
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_load |=> rx_flag);

    // R4
    rx_rose_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(ev_rx_load));

    // R8
    hi_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && bus_rd && bus_addr == DATA_ADDR && bus_lane_hi && !bus_lane_lo)
        |=> rx_flag);

    // R13
    fault_unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_flag && !mf_arm && bus_wr && bus_addr == CTRL1_ADDR) |=> mf_flag);

    // R11
    tx_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_taken |=> tx_flag);

    // R14
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_flag |-> !irq_rx);

    // R3
    stat_wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STAT_ADDR && !ev_rx_load) |=> (rx_flag == $past(rx_flag)));
endmodule

bind spi_flag_status spi_flag_status_chk #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
    .CTRL1_ADDR(CTRL1_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_lane_hi(bus_lane_hi), .bus_lane_lo(bus_lane_lo),
    .bus_rdata(bus_rdata), .ev_rx_load(ev_rx_load), .ev_tx_taken(ev_tx_taken),
    .rx_flag(rx_flag), .mf_flag(mf_flag), .mf_arm(mf_arm), .tx_flag(tx_flag),
    .irq_rx(irq_rx)
);

// File: tb/tb_spi_flag_status.sv
`timescale 1ns/1ps
module tb_spi_flag_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 0, bus_wr = 0, bus_lane_hi = 0, bus_lane_lo = 0;
    logic [7:0] bus_rdata;
    logic       ev_rx_load = 0, ev_tx_taken = 0, ev_tx_written = 0;
    logic       ss_in = 1, master_en = 0, fault_det_en = 0, wide = 0;
    logic       rx_irq_en = 1, tx_irq_en = 1, fault_irq_en = 1;
    logic       irq_rx, irq_tx, irq_fault;

    typedef struct {
        logic [7:0] stat;
        logic [2:0] irq;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_flag_status dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_lane_hi(bus_lane_hi), .bus_lane_lo(bus_lane_lo),
        .bus_rdata(bus_rdata), .ev_rx_load(ev_rx_load), .ev_tx_taken(ev_tx_taken),
        .ev_tx_written(ev_tx_written), .ss_in(ss_in), .master_en(master_en),
        .fault_det_en(fault_det_en), .wide(wide), .rx_irq_en(rx_irq_en),
        .tx_irq_en(tx_irq_en), .fault_irq_en(fault_irq_en),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_fault(irq_fault)
    );

    // monitor: compares each status read against the scoreboard head
    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (bus_rd && bus_addr == 3'h3 && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                vectors++;
                if (bus_rdata !== e.stat || {irq_rx, irq_tx, irq_fault} !== e.irq) begin
                    miscompares++;
                    $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                             e.tag, bus_rdata, {irq_rx, irq_tx, irq_fault}, e.stat, e.irq);
                end
            end
        end
    end

    task automatic release_all();
        @(posedge clk);
        #1;
        bus_rd = 0; bus_wr = 0; bus_lane_hi = 0; bus_lane_lo = 0;
        ev_rx_load = 0; ev_tx_taken = 0; ev_tx_written = 0;
    endtask

    task automatic st_rd(input logic [7:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        e.stat = exp;
        e.irq  = {exp[7] & rx_irq_en, exp[5] & tx_irq_en, exp[4] & fault_irq_en};
        e.tag  = tag;
        sb_q.push_back(e);
        bus_addr = 3'h3; bus_rd = 1; bus_lane_lo = 1;
        release_all();
    endtask

    task automatic data_rd(input logic hi, input logic lo);
        @(negedge clk);
        bus_addr = 3'h4; bus_rd = 1; bus_lane_hi = hi; bus_lane_lo = lo;
        release_all();
    endtask

    task automatic reg_wr(input logic [2:0] a);
        @(negedge clk);
        bus_addr = a; bus_wr = 1; bus_lane_lo = 1;
        release_all();
    endtask

    task automatic rx_ev();
        @(negedge clk);
        ev_rx_load = 1;
        release_all();
    endtask

    task automatic ss_set(input logic v);
        @(negedge clk);
        ss_in = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset value
        st_rd(8'h20, "R1 reset");
        // R3 status write ignored
        reg_wr(3'h3);
        st_rd(8'h20, "R3 status write");
        // R4 / R2 receive set and layout
        rx_ev();
        st_rd(8'hA0, "R4 rx set");
        // R5 8-bit low read clears
        data_rd(0, 1);
        st_rd(8'h20, "R5 low read clear");
        // R6 unarmed low read
        rx_ev();
        data_rd(0, 1);
        st_rd(8'hA0, "R6 unarmed");
        data_rd(0, 1);
        st_rd(8'h20, "R6 armed then clear");
        // R7 8-bit word read does not clear
        rx_ev();
        st_rd(8'hA0, "R7 set");
        data_rd(1, 1);
        st_rd(8'hA0, "R7 word read in 8-bit");
        data_rd(0, 1);
        st_rd(8'h20, "R7 low read after");
        // R8 / R9 16-bit sequences
        wide = 1;
        rx_ev();
        st_rd(8'hA0, "R8 set");
        data_rd(1, 0); data_rd(1, 0); data_rd(1, 0);
        st_rd(8'hA0, "R8 high reads");
        data_rd(0, 1);
        st_rd(8'h20, "R9 low alone");
        rx_ev();
        st_rd(8'hA0, "R9 set");
        data_rd(1, 0); data_rd(0, 1);
        st_rd(8'h20, "R9 high then low");
        rx_ev();
        st_rd(8'hA0, "R9 set word");
        data_rd(1, 1);
        st_rd(8'h20, "R9 word read");
        // R10 new event between arm and clear
        rx_ev();
        st_rd(8'hA0, "R10 set");
        rx_ev();
        data_rd(0, 1);
        st_rd(8'hA0, "R10 re-set cancels arm");
        data_rd(0, 1);
        st_rd(8'h20, "R10 clear after");
        // R10 same-cycle set and clear
        rx_ev();
        st_rd(8'hA0, "R10 set2");
        @(negedge clk);
        bus_addr = 3'h4; bus_rd = 1; bus_lane_lo = 1; ev_rx_load = 1;
        release_all();
        st_rd(8'hA0, "R10 same cycle");
        data_rd(0, 1);
        st_rd(8'h20, "R10 clear2");
        // R11 transmit empty
        @(negedge clk); ev_tx_written = 1; release_all();
        st_rd(8'h00, "R11 armed write clears");
        @(negedge clk); ev_tx_taken = 1; release_all();
        @(negedge clk); ev_tx_written = 1; release_all();
        st_rd(8'h20, "R11 unarmed write");
        // R12 mode fault set conditions
        master_en = 1; fault_det_en = 0;
        ss_set(0); ss_set(1);
        st_rd(8'h20, "R12 detection off");
        master_en = 0; fault_det_en = 1;
        ss_set(0); ss_set(1);
        st_rd(8'h20, "R12 not master");
        master_en = 1;
        ss_set(0);
        st_rd(8'h30, "R12 fault set");
        // R13 clear sequences
        reg_wr(3'h0);
        st_rd(8'h20, "R13 armed ctrl write");
        ss_set(1); ss_set(0);
        reg_wr(3'h0);
        st_rd(8'h30, "R13 unarmed ctrl write");
        reg_wr(3'h0);
        st_rd(8'h20, "R13 clear");
        // R14 enables gate interrupts
        rx_ev();
        rx_irq_en = 0; tx_irq_en = 0;
        st_rd(8'hA0, "R14 enables off");
        rx_irq_en = 1; fault_irq_en = 0;
        st_rd(8'hA0, "R14 rx enabled");
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            miscompares++;
            $display("FAIL scoreboard: %0d pending, expected 0", sb_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule